// File: doc/BRIEF.md
# Dual-Code Punctured Convolutional Encoder

A streaming forward error correction encoder. Serial data bits arrive on a valid/ready input and leave as coded bits on a valid/ready output. For each frame a 3-bit FEC type, captured on a frame-start pulse, selects one of five behaviours. The choices are an uncoded pass-through, a constraint-length-6 code at rate 1/2 or 3/4, and a constraint-length-4 code at rate 1/2 or 3/4.

Both codes are rate-1/2 feed-forward shift-register codes. Rate 3/4 is derived from either code by deleting two of every six mother bits. A flush request pushes K-1 zero tail bits through the active code, which returns the trellis to the all-zero state at the end of a frame. Reserved FEC type values raise an error flag, and the frame is then carried uncoded.

Top module: `fec_dual_encoder`

## Requirements
- R1: After reset `out_valid` and `cfg_error` are 0, `in_ready` is 1, and the block passes bits through uncoded until the first frame start.
- R2: `fec_type` is sampled only in a cycle with `frame_start` high. Changes to `fec_type` at other times affect neither the coded stream nor `cfg_error`.
- R3: FEC type 0 (binary 000) emits each accepted input bit exactly once, unchanged and in order.
- R4: FEC type 1 (001) uses constraint length 6. For each input bit it forms the window w = {new bit, previous 5 bits with the most recent first}. It emits parity(w & 65 octal) and then parity(w & 57 octal).
- R5: FEC type 3 (011) does the same with constraint length 4, window {new bit, previous 3 bits}, and generators 15 and 17 octal.
- R6: FEC types 2 (010, K=6) and 4 (100, K=4) puncture to rate 3/4 over groups of three input bits. Call the first-generator bits A and the second-generator bits B. The kept bits are A0 B0 A1 B2, and B1 and A2 are dropped. The group position restarts at frame start and continues through tail bits.
- R7: FEC types 5, 6 and 7 set `cfg_error` from the frame start until the next frame start, and that frame is passed through uncoded. A frame start with a valid type clears the flag one cycle later.
- R8: A frame start clears the shift registers and the puncture position, and discards any coded bits not yet delivered. `out_valid` is 0 in the following cycle.
- R9: A flush request in a coded mode encodes K-1 zero tail bits through the active code and puncturing. `in_ready` stays 0 while tail bits are pending. In uncoded modes a flush adds no bits.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_bit` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse starting a frame; captures `fec_type` |
| fec_type | input | 3 | FEC type code for the frame being started |
| flush_req | input | 1 | One-cycle pulse requesting the zero tail |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Encoder accepts an input bit this cycle |
| in_bit | input | 1 | Input data bit |
| out_valid | output | 1 | Coded bit available |
| out_ready | input | 1 | Downstream accepts the coded bit |
| out_bit | output | 1 | Coded bit |
| cfg_error | output | 1 | Reserved FEC type captured for the current frame |

## Verification
The hardest state to reach is a frame start that arrives while coded bits are still held back by output backpressure. The check there is that neither those bits nor the shift register contents carry into the next frame. The bench holds `out_ready` low, feeds one bit so that two coded bits are pending, and then restarts the frame. After the restart the output must go idle and the new frame's bits must match a model whose history is zero. Rate-3/4 frames use bit counts that are not multiples of three, so the tail bits begin in the middle of a puncture group. Random backpressure exercises the case where a new bit is loaded in the same cycle that the last pending bit leaves.

// File: rtl/fec_enc_pkg.sv
package fec_enc_pkg;

  typedef struct packed {
    logic coded;    // a convolutional code is active
    logic use_b;    // short code selected
    logic punct;    // rate 3/4 deletion active
    logic bad;      // reserved type value
  } fec_mode_t;

  function automatic fec_mode_t fec_decode(input logic [2:0] t);
    fec_mode_t m;
    m = '0;
    case (t)
      3'd0: m = '0;
      3'd1: m.coded = 1'b1;
      3'd2: begin m.coded = 1'b1; m.punct = 1'b1; end
      3'd3: begin m.coded = 1'b1; m.use_b = 1'b1; end
      3'd4: begin m.coded = 1'b1; m.use_b = 1'b1; m.punct = 1'b1; end
      default: m.bad = 1'b1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fec_conv_core.sv
module fec_conv_core #(
  parameter int K = 6,
  parameter logic [K-1:0] G0 = '1,
  parameter logic [K-1:0] G1 = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic din,
  output logic g0,
  output logic g1
);
  // hist[K-2] is the most recent past bit
  logic [K-2:0] hist;
  logic [K-1:0] win;

  assign win = {din, hist};
  assign g0  = ^(win & G0);
  assign g1  = ^(win & G1);

  always_ff @(posedge clk) begin
    if (rst || clr) hist <= '0;
    else if (step)  hist <= win[K-1:1];
  end
endmodule

// File: rtl/fec_puncture.sv
module fec_puncture (
  input  logic       coded,
  input  logic       punct,
  input  logic [1:0] phase,
  input  logic       raw,
  input  logic       ga,
  input  logic       gb,
  output logic [1:0] cnt,
  output logic [1:0] bits
);
  // bits[0] leaves first
  always_comb begin
    cnt  = 2'd2;
    bits = {gb, ga};
    if (!coded) begin
      cnt  = 2'd1;
      bits = {1'b0, raw};
    end else if (punct) begin
      case (phase)
        2'd1:    begin cnt = 2'd1; bits = {1'b0, ga}; end
        2'd2:    begin cnt = 2'd1; bits = {1'b0, gb}; end
        default: begin cnt = 2'd2; bits = {gb, ga}; end
      endcase
    end
  end
endmodule

// File: rtl/fec_dual_encoder.sv
module fec_dual_encoder
  import fec_enc_pkg::*;
#(
  parameter int KA = 6,
  parameter logic [KA-1:0] GA0 = 6'o65,
  parameter logic [KA-1:0] GA1 = 6'o57,
  parameter int KB = 4,
  parameter logic [KB-1:0] GB0 = 4'o15,
  parameter logic [KB-1:0] GB1 = 4'o17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic [2:0] fec_type,
  input  logic       flush_req,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_bit,
  output logic       cfg_error
);
  localparam int KMAX = (KA > KB) ? KA : KB;
  localparam int TW   = $clog2(KMAX);

  logic [2:0]    cur_type;
  fec_mode_t     mode;
  logic [1:0]    pend_cnt;
  logic [1:0]    pend_bits;
  logic [1:0]    phase;
  logic [TW-1:0] tail_left;
  logic [TW-1:0] tail_n;
  logic          tail_busy, can_load, load, src_bit;
  logic          a_g0, a_g1, b_g0, b_g1, sel_g0, sel_g1;
  logic [1:0]    new_cnt, new_bits;

  assign mode      = fec_decode(cur_type);
  assign tail_n    = !mode.coded ? '0 : (mode.use_b ? TW'(KB - 1) : TW'(KA - 1));
  assign tail_busy = (tail_left != '0);
  assign can_load  = (pend_cnt == 2'd0) || (pend_cnt == 2'd1 && out_ready);
  assign in_ready  = can_load && !tail_busy && !frame_start && !flush_req;
  assign load      = can_load && !frame_start && (tail_busy || (in_valid && !flush_req));
  assign src_bit   = tail_busy ? 1'b0 : in_bit;

  fec_conv_core #(.K(KA), .G0(GA0), .G1(GA1)) u_code_a (
    .clk(clk), .rst(rst), .clr(frame_start), .step(load),
    .din(src_bit), .g0(a_g0), .g1(a_g1));

  fec_conv_core #(.K(KB), .G0(GB0), .G1(GB1)) u_code_b (
    .clk(clk), .rst(rst), .clr(frame_start), .step(load),
    .din(src_bit), .g0(b_g0), .g1(b_g1));

  assign sel_g0 = mode.use_b ? b_g0 : a_g0;
  assign sel_g1 = mode.use_b ? b_g1 : a_g1;

  fec_puncture u_punct (
    .coded(mode.coded), .punct(mode.punct), .phase(phase),
    .raw(src_bit), .ga(sel_g0), .gb(sel_g1),
    .cnt(new_cnt), .bits(new_bits));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_type  <= 3'd0;
      cfg_error <= 1'b0;
      pend_cnt  <= 2'd0;
      pend_bits <= 2'd0;
      phase     <= 2'd0;
      tail_left <= '0;
    end else if (frame_start) begin
      cur_type  <= fec_type;
      cfg_error <= (fec_type > 3'd4);
      pend_cnt  <= 2'd0;
      phase     <= 2'd0;
      tail_left <= '0;
    end else begin
      if (flush_req && !tail_busy) tail_left <= tail_n;
      else if (load && tail_busy)  tail_left <= tail_left - 1'b1;

      if (load) begin
        pend_cnt  <= new_cnt;
        pend_bits <= new_bits;
        if (mode.punct) phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
      end else if (out_valid && out_ready) begin
        pend_cnt  <= pend_cnt - 2'd1;
        pend_bits <= {1'b0, pend_bits[1]};
      end
    end
  end

  assign out_valid = (pend_cnt != 2'd0);
  assign out_bit   = pend_bits[0];
endmodule

// File: rtl/fec_dual_encoder_chk.sv
module fec_dual_encoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_start,
  input logic [2:0] fec_type,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_bit,
  input logic       cfg_error,
  input logic       tail_busy,
  input logic [1:0] pend_cnt,
  input logic [1:0] phase
);
  // R10: stalled output is held
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !frame_start |=> out_valid && $stable(out_bit));

  // R9: no input accepted while tail bits remain
  a_r9_tail_blocks: assert property (@(posedge clk) disable iff (rst)
    tail_busy |-> !in_ready);

  // R7: flag follows the captured type
  a_r7_flag: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> cfg_error == ($past(fec_type) > 3'd4));

  // R2: flag changes only through a frame start
  a_r2_flag_held: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(cfg_error));

  // R8: pending bits dropped by a frame start
  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !out_valid);

  // R6: group position and pending count stay in range
  a_r6_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase <= 2'd2 && pend_cnt <= 2'd2);
endmodule

bind fec_dual_encoder fec_dual_encoder_chk u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .fec_type(fec_type),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_bit(out_bit), .cfg_error(cfg_error), .tail_busy(tail_left != '0),
  .pend_cnt(pend_cnt), .phase(phase));

// File: tb/fec_dual_encoder_test.sv
`timescale 1ns/100ps
module fec_dual_encoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic [2:0] fec_type = 3'd0;
  logic flush_req = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, cfg_error;

  always #2.5 clk = ~clk;   // 200 MHz

  fec_dual_encoder uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .fec_type(fec_type),
    .flush_req(flush_req), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .cfg_error(cfg_error));

  int n_cmp = 0;
  int n_bad = 0;
  int rdy_mode = 0;   // 0 always ready, 1 random, 2 held low

  // reference model state
  int    m_type = 0;
  int    m_hist = 0;
  int    m_phase = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    prev_stall = 1'b0;
  bit    prev_bit = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_k();
    return (m_type == 3 || m_type == 4) ? 4 : 6;
  endfunction
  function automatic bit m_coded();
    return m_type >= 1 && m_type <= 4;
  endfunction
  function automatic string m_tag();
    case (m_type)
      0: return "R3";
      1: return "R4";
      3: return "R5";
      2, 4: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic void push(input bit b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endfunction

  function automatic void encode(input bit b, input string t);
    int k, w, ga, gb;
    bit a, bb;
    if (!m_coded()) begin
      push(b, t);
      return;
    end
    k  = m_k();
    ga = (k == 6) ? 'o65 : 'o15;
    gb = (k == 6) ? 'o57 : 'o17;
    w  = (int'(b) << (k - 1)) | m_hist;
    a  = ^(w & ga);
    bb = ^(w & gb);
    m_hist = w >> 1;
    if (m_type == 2 || m_type == 4) begin
      if (m_phase == 0) begin push(a, t); push(bb, t); end
      else if (m_phase == 1) push(a, t);
      else push(bb, t);
      m_phase = (m_phase + 1) % 3;
    end else begin
      push(a, t);
      push(bb, t);
    end
  endfunction

  // backpressure driver
  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // monitor, sampled half a cycle after inputs change
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (prev_stall) chk(out_valid && out_bit == prev_bit, "R10", int'(out_bit), int'(prev_bit));
      if (frame_start) begin
        m_type = int'(fec_type);
        m_hist = 0;
        m_phase = 0;
        exp_q.delete();
        tag_q.delete();
      end else begin
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(1'b0, m_tag(), int'(out_bit), -1);
          else begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_bit == e, t, int'(out_bit), int'(e));
          end
        end
        if (in_valid && in_ready) encode(in_bit, m_tag());
        if (flush_req && m_coded())
          for (int i = 0; i < m_k() - 1; i++) encode(1'b0, "R9");
      end
      prev_stall = out_valid && !out_ready && !frame_start;
      prev_bit = out_bit;
    end
  end

  task automatic send_bit(input bit b);
    in_valid = 1'b1;
    in_bit = b;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_n(input int n);
    for (int i = 0; i < n; i++) send_bit(1'($urandom));
  endtask

  task automatic start_frame(input logic [2:0] t);
    frame_start = 1'b1;
    fec_type = t;
    @(negedge clk);
    frame_start = 1'b0;
    fec_type = 3'd7;   // junk between frame starts (R2)
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #2.2;
      if (exp_q.size() == 0 && !out_valid) break;
    end
    chk(exp_q.size() == 0 && !out_valid, tag, exp_q.size(), 0);
    @(negedge clk);
  endtask

  task automatic flush_check();
    bit coded;
    coded = m_coded();
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    #2;
    // R9: tail holds off input in coded modes; no tail when uncoded
    chk(in_ready == !coded, "R9", int'(in_ready), int'(!coded));
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [2:0] t, input int n);
    start_frame(t);
    send_n(n);
    drain(m_tag());
    flush_check();
    drain("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #2;
    chk(!out_valid, "R1", int'(out_valid), 0);
    chk(!cfg_error, "R1", int'(cfg_error), 0);
    chk(in_ready, "R1", int'(in_ready), 1);
    @(negedge clk);

    // R1/R3: uncoded before any frame start
    send_n(8);
    drain("R1");

    rdy_mode = 1;
    run_frame(3'd1, 40);   // R4
    #2;
    chk(!cfg_error, "R2", int'(cfg_error), 0);   // fec_type held at 7 meanwhile
    @(negedge clk);
    run_frame(3'd3, 40);   // R5
    run_frame(3'd2, 41);   // R6, K=6, tail starts mid-group
    run_frame(3'd4, 31);   // R6, K=4
    run_frame(3'd0, 12);   // R3

    // R7: reserved type
    start_frame(3'd6);
    #2;
    chk(cfg_error, "R7", int'(cfg_error), 1);
    @(negedge clk);
    send_n(10);
    drain("R7");
    flush_check();
    drain("R7");
    start_frame(3'd1);
    #2;
    chk(!cfg_error, "R7", int'(cfg_error), 0);
    @(negedge clk);

    // R8: restart with coded bits still pending
    rdy_mode = 2;
    @(negedge clk);
    send_bit(1'b1);
    @(negedge clk);
    start_frame(3'd1);
    #2;
    chk(!out_valid, "R8", int'(out_valid), 0);
    @(negedge clk);
    rdy_mode = 1;
    send_n(20);
    drain("R8");
    flush_check();
    drain("R9");

    rdy_mode = 0;
    run_frame(3'd4, 23);
    run_frame(3'd1, 9);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule